// File: doc/BRIEF.md
# Full-Duplex Serial ADC Command Front-End

This block sits on a byte-wide register bus and drives a set of serial analog-to-digital converters, two by default, each with eight inputs. Software writes an 8-bit command byte to a converter's command register. The block then runs one full-duplex serial frame to that converter. During the frame it sends the new command and receives the result of the conversion that the previous command set up. When the frame ends, the 16 received bits go into two read registers and the data-ready flag in the status register rises.

The converter runs its conversion after a frame, so every returned sample lags its command by one frame. Software must therefore issue a throw-away flush command before the first real one. It can also chain commands so that each read collects the sample that the previous command asked for. The command byte packs four fields: bit 7 selects single-ended mode, bit 6 selects the odd input of a pair, bits 5:4 give the pair index and bits 3:2 give the range code. The block forwards the byte untouched. Host channels 8 to 15 reach inputs 0 to 7 of the second converter through its register window, which starts four bytes above the first.

Top module: `adc_cmd_frontend`

## Requirements
- R1: After reset, every register reads 0, every chip select is high (inactive), every serial clock is low and `irq` is low.
- R2: Address bits [1:0] pick the register inside a converter window: 0 is the result low byte, 1 is the result high byte, 2 is the command and 3 is the status. The upper address bits pick the converter, so converter k starts at byte 4k and host channels 8 to 15 are served by converter 1.
- R3: An accepted command write pulls that converter's chip select low for exactly 16 serial-clock periods of `SCLK_DIV` system clocks each. The serial clock idles low. The outgoing data changes only when the serial clock falls and the incoming data is sampled when it rises. The command byte goes out first, MSB first, followed by eight zero bits.
- R4: When a frame ends, the result registers take the 16 received bits, first bit as the MSB. This value is the conversion requested by the previous command to that converter. The first frame after reset returns whatever the converter held. The result registers change at no other time.
- R5: Status bit 7 (data ready) clears on an accepted command write and sets when the result registers are loaded. Status bit 6 reads 1 while a frame is in flight.
- R6: A command write that arrives while a frame is in flight has no effect on the frame or on the command readback, and it sets the sticky status bit 1 (overrun). Writing status with bit 1 set clears the overrun flag.
- R7: Status bit 0 is a writable interrupt enable. Status bit 4 (interrupt pending) sets when a result is loaded while the enable is 1, and clears on the next accepted command. `irq` is the OR of the pending bits of all converters.
- R8: Status bit 3 is a writable view select. While it is 1, offset 2 reads and writes an 8-bit resource-enable byte and starts no frame. While it is 0, offset 2 reads back the last accepted command.
- R9: Writes to offsets 0 and 1 are ignored.
- R10: A command write sampled in the last cycle of a frame counts as an overrun, and data ready still sets. A command write sampled in the cycle in which the result is loaded is accepted: the finished result is stored, data ready stays clear and a new frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (3) | Byte address: converter select above a 2-bit register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | OR of all interrupt-pending bits |
| adc_sclk | output | NUM_CONV | Serial clock per converter |
| adc_cs_n | output | NUM_CONV | Active-low chip select per converter |
| adc_mosi | output | NUM_CONV | Serial command data to each converter |
| adc_miso | input | NUM_CONV | Serial result data from each converter |

## Verification
Two events can land on the same clock edge: the end of a frame, and the next command write from software. The bench counts the exact frame length from its own accepted write. It then places a second command on the last busy cycle, and once more on the cycle in which the result is loaded. In the first case it expects an overrun with data ready set. In the second it expects the finished sample stored with data ready still low, and the following frame to return the sample of the command that straddled the edge.

// File: rtl/adcfe_pkg.sv
// Package: shared offsets, field positions and the status layout for the
// serial ADC command front-end. Assumes byte-wide registers.
package adcfe_pkg;

    localparam int BYTE_W     = 8;
    localparam int FRAME_BITS = 16;

    localparam logic [1:0] OFS_RES_LO = 2'd0;
    localparam logic [1:0] OFS_RES_HI = 2'd1;
    localparam logic [1:0] OFS_CMD    = 2'd2;
    localparam logic [1:0] OFS_STAT   = 2'd3;

    // Bit positions that software writes into the status register
    localparam int ST_IRQ_EN   = 0;
    localparam int ST_OVR_CLR  = 1;
    localparam int ST_VIEW_SEL = 3;

    // Status read layout, MSB first
    typedef struct packed {
        logic ready;      // 7
        logic busy;       // 6
        logic rsv5;       // 5
        logic irq_pend;   // 4
        logic view_sel;   // 3
        logic rsv2;       // 2
        logic overrun;    // 1
        logic irq_en;     // 0
    } adcfe_stat_t;

endpackage

// File: rtl/adc_serial_engine.sv
// Module: full-duplex serial frame engine for one converter.
// Sends a command byte followed by zeros, MSB first, and captures 16 bits
// at the same time. The serial clock idles low, outgoing data moves on its
// falling edge and incoming data is sampled on its rising edge.
// Assumes DIV is even and at least 2. A start request is taken only when idle.
module adc_serial_engine
    import adcfe_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [BYTE_W-1:0]     cmd,
    input  logic                  miso,
    output logic                  busy,
    output logic                  done,
    output logic [FRAME_BITS-1:0] result,
    output logic                  sclk,
    output logic                  cs_n,
    output logic                  mosi
);
    localparam int HALF  = DIV / 2;
    localparam int HC_W  = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BC_W  = $clog2(FRAME_BITS);
    localparam int EC_W  = BC_W + 1;
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF - 1);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(FRAME_BITS - 1);

    logic [HC_W-1:0]       half_cnt;
    logic [BC_W-1:0]       bit_cnt;
    logic [FRAME_BITS-1:0] tx_q;
    logic [FRAME_BITS-1:0] rx_q;
    logic                  sclk_q;

    // Frame sequencer: half-period timer, clock toggling, shift in and out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            half_cnt <= '0;
            bit_cnt  <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
            sclk_q   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy     <= 1'b1;
                    tx_q     <= {cmd, {(FRAME_BITS-BYTE_W){1'b0}}};
                    bit_cnt  <= '0;
                    half_cnt <= '0;
                end
            end else if (half_cnt == HC_LAST) begin
                half_cnt <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[FRAME_BITS-2:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    tx_q   <= {tx_q[FRAME_BITS-2:0], 1'b0};
                    if (bit_cnt == BC_LAST) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end else begin
                half_cnt <= half_cnt + 1'b1;
            end
        end
    end

    assign result = rx_q;
    assign sclk   = sclk_q;
    assign cs_n   = ~busy;
    assign mosi   = tx_q[FRAME_BITS-1];

    // Checker state: rising serial-clock edges seen in the current frame
    logic [EC_W-1:0] edge_cnt;
    logic            sclk_d;

    // Edge counter for the frame-length assertion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt <= '0;
            sclk_d   <= 1'b0;
        end else begin
            sclk_d <= sclk_q;
            if (start && !busy)
                edge_cnt <= '0;
            else if (sclk_q && !sclk_d)
                edge_cnt <= edge_cnt + 1'b1;
        end
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);                                               // R3
    AST_SIXTEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (edge_cnt == EC_W'(FRAME_BITS)));                     // R3
    AST_MOSI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$fell(sclk) && !$rose(busy)) |-> $stable(mosi));    // R3

endmodule

// File: rtl/adc_conv_regs.sv
// Module: register window for one converter. Holds the command, result,
// status and resource-enable registers and drives one serial engine.
// Assumes a single-cycle write strobe already qualified by converter select.
module adc_conv_regs
    import adcfe_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        offset,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq,
    input  logic              miso,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi
);
    logic                  busy, done;
    logic [FRAME_BITS-1:0] eng_result;
    logic [FRAME_BITS-1:0] res_q;
    logic [BYTE_W-1:0]     cmd_q, res_en_q;
    logic                  ready, irq_pend, irq_en, view_sel, overrun;
    logic                  cmd_hit, start, ovr_set, stat_wr, ren_wr;
    adcfe_stat_t           stat;

    assign cmd_hit = wr_en && (offset == OFS_CMD) && !view_sel;
    assign start   = cmd_hit && !busy;
    assign ovr_set = cmd_hit && busy;
    assign stat_wr = wr_en && (offset == OFS_STAT);
    assign ren_wr  = wr_en && (offset == OFS_CMD) && view_sel;

    adc_serial_engine #(.DIV(DIV)) i_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .cmd    (wdata),
        .miso   (miso),
        .busy   (busy),
        .done   (done),
        .result (eng_result),
        .sclk   (sclk),
        .cs_n   (cs_n),
        .mosi   (mosi)
    );

    // Command and resource-enable storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            res_en_q <= '0;
        end else begin
            if (start)  cmd_q    <= wdata;
            if (ren_wr) res_en_q <= wdata;
        end
    end

    // Result capture at frame end
    always_ff @(posedge clk) begin
        if (!rst_n)    res_q <= '0;
        else if (done) res_q <= eng_result;
    end

    // Data-ready and interrupt-pending flags; a new command wins over completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready    <= 1'b0;
            irq_pend <= 1'b0;
        end else if (start) begin
            ready    <= 1'b0;
            irq_pend <= 1'b0;
        end else if (done) begin
            ready    <= 1'b1;
            irq_pend <= irq_en;
        end
    end

    // Software control bits and sticky overrun
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en   <= 1'b0;
            view_sel <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            if (stat_wr) begin
                irq_en   <= wdata[ST_IRQ_EN];
                view_sel <= wdata[ST_VIEW_SEL];
            end
            if (ovr_set)
                overrun <= 1'b1;
            else if (stat_wr && wdata[ST_OVR_CLR])
                overrun <= 1'b0;
        end
    end

    // Status assembly and read-back mux
    always_comb begin
        stat          = '0;
        stat.ready    = ready;
        stat.busy     = busy;
        stat.irq_pend = irq_pend;
        stat.view_sel = view_sel;
        stat.overrun  = overrun;
        stat.irq_en   = irq_en;
        unique case (offset)
            OFS_RES_LO: rdata = res_q[BYTE_W-1:0];
            OFS_RES_HI: rdata = res_q[FRAME_BITS-1:BYTE_W];
            OFS_CMD:    rdata = view_sel ? res_en_q : cmd_q;
            default:    rdata = stat;
        endcase
    end

    assign irq = irq_pend;

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ready);                                             // R5
    AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_set |=> overrun);                                          // R6
    AST_IGNORED_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_set |=> $stable(cmd_q));                                   // R6
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(res_q));                                     // R4
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pend) |-> $past(done && irq_en));                    // R7
    AST_VIEW_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_wr && !busy) |=> !busy);                                  // R8

endmodule

// File: rtl/adc_cmd_frontend.sv
// Module: top of the serial ADC command front-end. Decodes the byte address
// into converter windows of four registers and muxes read data back.
// Assumes reads are combinational and writes last one cycle.
module adc_cmd_frontend
    import adcfe_pkg::*;
#(
    parameter  int NUM_CONV = 2,
    parameter  int SCLK_DIV = 4,
    localparam int SEL_W    = (NUM_CONV > 1) ? $clog2(NUM_CONV) : 1,
    localparam int ADDR_W   = SEL_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    output logic [NUM_CONV-1:0] adc_sclk,
    output logic [NUM_CONV-1:0] adc_cs_n,
    output logic [NUM_CONV-1:0] adc_mosi,
    input  logic [NUM_CONV-1:0] adc_miso
);
    logic [SEL_W-1:0]  conv_sel;
    logic [1:0]        reg_ofs;
    logic [BYTE_W-1:0] rd_arr  [NUM_CONV];
    logic [NUM_CONV-1:0] irq_vec;

    assign conv_sel = bus_addr[ADDR_W-1:2];
    assign reg_ofs  = bus_addr[1:0];

    for (genvar k = 0; k < NUM_CONV; k++) begin : g_conv
        adc_conv_regs #(.DIV(SCLK_DIV)) i_regs (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (bus_wr && (conv_sel == SEL_W'(k))),
            .offset (reg_ofs),
            .wdata  (bus_wdata),
            .rdata  (rd_arr[k]),
            .irq    (irq_vec[k]),
            .miso   (adc_miso[k]),
            .sclk   (adc_sclk[k]),
            .cs_n   (adc_cs_n[k]),
            .mosi   (adc_mosi[k])
        );
    end

    // Read-back selection across converter windows
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_CONV; k++)
            if (conv_sel == SEL_W'(k)) bus_rdata = rd_arr[k];
    end

    assign irq = |irq_vec;

endmodule

// File: tb/test_adc_cmd_frontend.sv
module test_adc_cmd_frontend;
    localparam int DIV   = 4;
    localparam int XFER  = 16 * DIV;
    localparam logic [15:0] FLUSH = 16'hC0DE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic [1:0] adc_sclk, adc_cs_n, adc_mosi, adc_miso;

    int n_chk = 0;
    int n_err = 0;
    logic [15:0] expv [2];
    logic [7:0]  d, lo, hi;

    always #2 clk = ~clk;

    adc_cmd_frontend #(.NUM_CONV(2), .SCLK_DIV(DIV)) i_adc_cmd_frontend (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .adc_sclk(adc_sclk), .adc_cs_n(adc_cs_n), .adc_mosi(adc_mosi),
        .adc_miso(adc_miso)
    );

    function automatic logic [15:0] smp(int g, logic [7:0] c);
        return {c ^ 8'h3C, ~c} ^ ((g != 0) ? 16'h8001 : 16'h0000);
    endfunction

    function automatic logic [7:0] mkcmd(logic se, logic [3:0] ch, logic [1:0] rng);
        return {se, ch[0], ch[2:1], rng, 2'b00};
    endfunction

    // Behavioural converters: shift out the previous sample, capture the command
    for (genvar g = 0; g < 2; g++) begin : g_adc
        logic [15:0] sh = 16'h0;
        logic [15:0] prev = FLUSH;
        logic [15:0] cap = 16'h0;
        logic [15:0] got = 16'h0;
        logic lcs = 1'b1, lsc = 1'b0;
        int rises = 0, last_rises = 0, cs_len = 0, last_len = 0;
        assign adc_miso[g] = sh[15];
        always @(adc_cs_n[g], adc_sclk[g]) begin
            if (lcs === 1'b1 && adc_cs_n[g] === 1'b0) begin
                sh = prev; rises = 0;
            end else if (adc_cs_n[g] === 1'b0 && lsc === 1'b1 && adc_sclk[g] === 1'b0)
                sh = {sh[14:0], 1'b0};
            if (adc_cs_n[g] === 1'b0 && lsc === 1'b0 && adc_sclk[g] === 1'b1) begin
                cap = {cap[14:0], adc_mosi[g]}; rises++;
            end
            if (lcs === 1'b0 && adc_cs_n[g] === 1'b1) begin
                got = cap; prev = smp(g, cap[15:8]); last_rises = rises;
            end
            lcs = adc_cs_n[g]; lsc = adc_sclk[g];
        end
        always @(negedge clk) begin
            if (adc_cs_n[g] === 1'b0) cs_len++;
            else if (cs_len != 0) begin last_len = cs_len; cs_len = 0; end
        end
    end

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] v);
        @(negedge clk); bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic wait_ready(int c);
        logic [7:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd(3'(c*4+3), s);
            if (s[7]) break;
        end
        check("R5 ready after frame", 16'(s[7]), 16'd1);
    endtask

    task automatic frame_info(int c, output logic [15:0] got, output int len, output int rises);
        if (c == 0) begin got = g_adc[0].got; len = g_adc[0].last_len; rises = g_adc[0].last_rises; end
        else        begin got = g_adc[1].got; len = g_adc[1].last_len; rises = g_adc[1].last_rises; end
    endtask

    // Reads the result and checks it and the frame just completed
    task automatic collect(int c, logic [7:0] cmd);
        logic [15:0] got; int len, rises;
        rd(3'(c*4+0), lo); rd(3'(c*4+1), hi);
        check("R4 result is previous command's sample", {hi, lo}, expv[c]);
        expv[c] = smp(c, cmd);
        frame_info(c, got, len, rises);
        check("R3 command then zeros shifted MSB first", got, {cmd, 8'h00});
        check("R3 chip select low 16 serial periods", 16'(len), 16'(XFER));
        check("R3 sixteen serial clock rises", 16'(rises), 16'd16);
    endtask

    task automatic xfer(int c, logic [7:0] cmd);
        wr(3'(c*4+2), cmd);
        wait_ready(c);
        collect(c, cmd);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [7:0] ca, cb;
        void'($urandom(32'd4242));
        expv[0] = FLUSH; expv[1] = FLUSH;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 register reset value", 16'(d), 16'h0);
        end
        check("R1 chip selects idle high", 16'(adc_cs_n), 16'h3);
        check("R1 serial clocks low", 16'(adc_sclk), 16'h0);
        check("R1 irq low", 16'(irq), 16'h0);

        // R4 flush then back-to-back on converter 0; R5 status while in flight
        ca = mkcmd(1'b1, 4'd3, 2'd1);
        wr(3'd2, ca);
        rd(3'd3, d);
        check("R5 ready low busy high in flight", 16'(d[7:6]), 16'b01);
        wait_ready(0); collect(0, ca);
        xfer(0, mkcmd(1'b0, 4'd6, 2'd2));

        // R2 channel 9 goes to converter 1 at byte 4
        xfer(1, mkcmd(1'b1, 4'd9, 2'd0));
        xfer(1, mkcmd(1'b0, 4'd14, 2'd3));

        // R9 writes to result registers are ignored
        rd(3'd0, lo); rd(3'd1, hi);
        wr(3'd0, ~lo); wr(3'd1, ~hi);
        rd(3'd0, d); check("R9 low byte write ignored", 16'(d), 16'(lo));
        rd(3'd1, d); check("R9 high byte write ignored", 16'(d), 16'(hi));

        // R6 overrun: second command while busy is dropped
        ca = mkcmd(1'b1, 4'd5, 2'd2); cb = 8'hEE;
        wr(3'd2, ca); wr(3'd2, cb);
        rd(3'd3, d); check("R6 overrun flag set", 16'(d[1]), 16'd1);
        rd(3'd2, d); check("R6 command readback unchanged", 16'(d), 16'(ca));
        wait_ready(0); collect(0, ca);
        wr(3'd3, 8'h02);
        rd(3'd3, d); check("R6 overrun cleared", 16'(d[1]), 16'd0);

        // R7 interrupt enable, pending, clear on command
        wr(3'd7, 8'h01);
        xfer(1, 8'h44);
        check("R7 irq raised", 16'(irq), 16'd1);
        rd(3'd7, d); check("R7 pending bit", 16'(d[4]), 16'd1);
        wr(3'd6, 8'h48);
        rd(3'd7, d); check("R7 pending cleared by command", 16'(d[4]), 16'd0);
        check("R7 irq dropped", 16'(irq), 16'd0);
        wait_ready(1); collect(1, 8'h48);
        wr(3'd7, 8'h00);
        xfer(1, 8'h4C);
        check("R7 no irq when disabled", 16'(irq), 16'd0);

        // R8 resource-enable view
        wr(3'd3, 8'h08);
        wr(3'd2, 8'h5A);
        rd(3'd3, d); check("R8 no frame in alternate view", 16'(d[7:6]), 16'b10);
        rd(3'd2, d); check("R8 resource byte readback", 16'(d), 16'h5A);
        wr(3'd3, 8'h00);
        rd(3'd2, d); check("R8 command view readback", 16'(d), 16'(ca));

        // R10 command in the last busy cycle: overrun, ready still sets
        ca = 8'h90;
        wr(3'd2, ca);
        repeat (XFER-2) @(negedge clk);
        wr(3'd2, 8'h11);
        rd(3'd3, d); check("R10 last busy cycle is overrun", 16'({d[7], d[1]}), 16'b11);
        collect(0, ca);
        wr(3'd3, 8'h02);

        // R10 command in the result-load cycle: accepted, ready stays low
        ca = 8'hA4; cb = 8'h18;
        wr(3'd2, ca);
        repeat (XFER-1) @(negedge clk);
        wr(3'd2, cb);
        rd(3'd3, d); check("R10 load-cycle command accepted", 16'({d[7], d[6], d[1]}), 16'b010);
        rd(3'd0, lo); rd(3'd1, hi);
        check("R10 finished result stored", {hi, lo}, expv[0]);
        expv[0] = smp(0, ca);
        wait_ready(0); collect(0, cb);

        // Random commands over all 16 host channels (R2, R3, R4)
        for (int i = 0; i < 24; i++) begin
            logic [3:0] ch; logic [7:0] c;
            ch = 4'($urandom_range(15));
            c  = mkcmd(1'($urandom_range(1)), ch, 2'($urandom_range(3)));
            xfer(int'(ch[3]), c);
        end

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule